// File: doc/BRIEF.md
# Prioritized Event Vector Controller for a Two-Wire Serial Bus Controller

This block gathers the one-cycle event pulses produced by a two-wire serial bus controller into sticky flags and turns them into a single interrupt line and a small numeric vector. There are seven events: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit data ready, stop detected and addressed-as-slave. A mask register selects which events may raise the interrupt and appear in the vector. A status register shows the raw flags and two bus levels. A vector register reports the most urgent unmasked pending event.

Software services an interrupt by reading the vector again and again until it returns 0. Each read acknowledges the event it reports, so the next read moves on to the next pending event. The two data-ready flags are the exception. They stay set until the data path reports that the receive buffer was drained or the transmit buffer was refilled. Any flag can also be cleared by writing a one to its status bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask register, all event flags, the vector register and `irq_o` are 0.
- R2: A pulse on `evt_i[k]` sets flag k one clock later, whether or not it is masked. The status register (address 1) shows flag k at bit k. The event index is k=0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed-as-slave.
- R3: The vector register (address 2) reports event k as code k+1 in bits 2:0, with the upper bits 0. The codes run from arbitration lost = 1 to addressed-as-slave = 7.
- R4: The vector reads 0 when no flag is both set and enabled in the mask register (address 0, bit k enables event k). Masked flags never appear in the vector.
- R5: When several unmasked flags are pending, the vector reports the one with the smallest code.
- R6: A vector read that returns a nonzero code for events 0, 1, 2, 5 or 6 clears that flag at the end of the read cycle. The next read therefore reports the next pending event, and reads 0 once none is left.
- R7: A vector read does not clear the receive-ready flag (bit 3) or the transmit-ready flag (bit 4). A pulse on `rx_drained_i` clears bit 3, and a pulse on `tx_filled_i` clears bit 4.
- R8: A write to the status register clears every flag whose bit in bits 6:0 of the write data is 1. Flags written with 0 are unchanged.
- R9: An event pulse that arrives in the same cycle as a clear of its flag, by write-one, vector read or data-path pulse, leaves the flag set.
- R10: `irq_o` is 1 exactly when at least one flag is set with its mask bit set.
- R11: Status bit 11 shows the level of `rsfull_i` and status bit 12 shows the level of `busy_i`. Writing these bits has no effect.
- R12: The mask register stores bits 6:0 of the write data and reads back with bits 15:7 as 0. Reads from address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses, bit k is event k |
| rx_drained_i | input | 1 | Pulse: receive buffer was read; clears receive-ready |
| tx_filled_i | input | 1 | Pulse: transmit buffer was loaded; clears transmit-ready |
| rsfull_i | input | 1 | Level: receive shift register full |
| busy_i | input | 1 | Level: bus busy |
| bus_addr_i | input | 2 | Register address (0 mask, 1 status, 2 vector) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; a read of the vector acknowledges the event it reports |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register, valid in the same cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
A flag that is wrongly held or wrongly cleared shows up at the ports in the very next cycle: either on `irq_o` or in the vector sequence that a servicing loop reads. A broken priority chain gives the wrong code on the first vector read after a multi-event pulse. A missing acknowledge makes the same code repeat on the next read. A clear applied to a data-ready flag lets the vector advance past code 4 or 5 without the data-path pulse. Sweeping every combination of seven simultaneous events against several masks, and walking the full servicing loop each time, exposes each of these faults within a few cycles of the stimulus that causes it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   localparam int NUM_EVT = 7;

   typedef enum int unsigned {
      EV_ARB_LOST  = 0,
      EV_NO_ACK    = 1,
      EV_ACC_RDY   = 2,
      EV_RX_RDY    = 3,
      EV_TX_RDY    = 4,
      EV_STOP_SEEN = 5,
      EV_SLV_ADDR  = 6
   } ev_idx_e;

   // flags that a vector read leaves untouched (data-path owned)
   localparam logic [NUM_EVT-1:0] DATA_HELD = 7'b001_1000;

   localparam int REG_MASK = 0;
   localparam int REG_STAT = 1;
   localparam int REG_VEC  = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar k = 0; k < N; k++) begin : g_flag
      logic q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)        q <= 1'b0;
         else if (set_i[k])  q <= 1'b1;   // event beats clear (R9)
         else if (clr_i[k])  q <= 1'b0;
      end
      assign flag_o[k] = q;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N    = 7,
   parameter bit TREE = 1'b1,
   localparam int IW  = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   if (TREE) begin : g_tree
      localparam int P = 1 << IW;
      logic          nv   [2*P-1];
      logic [IW-1:0] nidx [2*P-1];
      for (genvar j = 0; j < P; j++) begin : g_leaf
         if (j < N) begin : g_real
            assign nv[P-1+j] = req_i[j];
         end else begin : g_pad
            assign nv[P-1+j] = 1'b0;
         end
         assign nidx[P-1+j] = IW'(j);
      end
      for (genvar k = 0; k < P-1; k++) begin : g_node
         assign nv[k]   = nv[2*k+1] | nv[2*k+2];
         assign nidx[k] = nv[2*k+1] ? nidx[2*k+1] : nidx[2*k+2];
      end
      assign any_o = nv[0];
      assign idx_o = nidx[0];
   end else begin : g_linear
      always_comb begin
         any_o = 1'b0;
         idx_o = '0;
         for (int j = N-1; j >= 0; j--) begin
            if (req_i[j]) begin
               any_o = 1'b1;
               idx_o = IW'(j);
            end
         end
      end
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
   parameter int N          = 7,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 2,
   parameter int CODE_W     = 3,
   parameter int A_MASK     = 0,
   parameter int A_STAT     = 1,
   parameter int A_VEC      = 2,
   parameter int RSFULL_BIT = 11,
   parameter int BUSY_BIT   = 12,
   parameter logic [N-1:0] KEEP = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [N-1:0]      flag_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [N-1:0]      hit_oh_i,
   input  logic              rsfull_i,
   input  logic              busy_i,
   output logic [N-1:0]      mask_o,
   output logic [N-1:0]      clr_o
);
   logic sel_mask, sel_stat, sel_vec;
   logic [N-1:0] mask_q;
   logic unused_wdata_hi;

   assign sel_mask = addr_i == ADDR_W'(A_MASK);
   assign sel_stat = addr_i == ADDR_W'(A_STAT);
   assign sel_vec  = addr_i == ADDR_W'(A_VEC);
   assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

   always_ff @(posedge clk_i) begin
      if (!rst_ni)               mask_q <= '0;
      else if (wr_i && sel_mask) mask_q <= wdata_i[N-1:0];
   end
   assign mask_o = mask_q;

   always_comb begin
      clr_o = '0;
      if (wr_i && sel_stat) clr_o = clr_o | wdata_i[N-1:0];
      if (rd_i && sel_vec)  clr_o = clr_o | (hit_oh_i & ~KEEP);
   end

   always_comb begin
      rdata_o = '0;
      if (sel_mask) begin
         rdata_o[N-1:0] = mask_q;
      end else if (sel_stat) begin
         rdata_o[N-1:0]    = flag_i;
         rdata_o[RSFULL_BIT] = rsfull_i;
         rdata_o[BUSY_BIT]   = busy_i;
      end else if (sel_vec) begin
         rdata_o[CODE_W-1:0] = code_i;
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 2,
   parameter int RSFULL_BIT = 11,
   parameter int BUSY_BIT   = 12,
   parameter bit TREE_ENC   = 1'b1,
   localparam int N         = NUM_EVT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N-1:0]      evt_i,
   input  logic              rx_drained_i,
   input  logic              tx_filled_i,
   input  logic              rsfull_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   localparam int IW     = $clog2(N);
   localparam int CODE_W = $clog2(N+1);

   if (N < 2) begin : g_bad_n
      $error("event count must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("three registers need at least 2 address bits");
   end
   if (RSFULL_BIT < N || BUSY_BIT < N || RSFULL_BIT == BUSY_BIT) begin : g_bad_lvl
      $error("level bits must sit above the flags and differ");
   end
   if (RSFULL_BIT >= DATA_W || BUSY_BIT >= DATA_W || CODE_W > DATA_W) begin : g_bad_w
      $error("register width too small for the field layout");
   end

   logic [N-1:0]      flag_q, mask_q, port_clr, data_clr, hit_oh;
   logic              enc_any;
   logic [IW-1:0]     enc_idx;
   logic [CODE_W-1:0] vec_code;

   assign data_clr = (N'(rx_drained_i) << EV_RX_RDY) | (N'(tx_filled_i) << EV_TX_RDY);

   irq_flag_bank #(.N(N)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i),
      .clr_i  (port_clr | data_clr),
      .flag_o (flag_q)
   );

   irq_prio_enc #(.N(N), .TREE(TREE_ENC)) u_enc (
      .req_i (flag_q & mask_q),
      .any_o (enc_any),
      .idx_o (enc_idx)
   );

   assign vec_code = enc_any ? CODE_W'(enc_idx) + CODE_W'(1) : '0;
   assign hit_oh   = enc_any ? (N'(1) << enc_idx) : '0;

   irq_reg_port #(
      .N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
      .A_MASK(REG_MASK), .A_STAT(REG_STAT), .A_VEC(REG_VEC),
      .RSFULL_BIT(RSFULL_BIT), .BUSY_BIT(BUSY_BIT), .KEEP(DATA_HELD)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (bus_addr_i),
      .wr_i     (bus_wr_i),
      .rd_i     (bus_rd_i),
      .wdata_i  (bus_wdata_i),
      .rdata_o  (bus_rdata_o),
      .flag_i   (flag_q),
      .code_i   (vec_code),
      .hit_oh_i (hit_oh),
      .rsfull_i (rsfull_i),
      .busy_i   (busy_i),
      .mask_o   (mask_q),
      .clr_o    (port_clr)
   );

   assign irq_o = |(flag_q & mask_q);
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
   import irq_vec_pkg::*;
#(
   parameter int N        = 7,
   parameter int CODE_W   = 3,
   parameter int ADDR_W   = 2,
   parameter int DATA_W   = 16,
   parameter int BUSY_BIT = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [N-1:0]      evt_i,
   input logic              rx_drained_i,
   input logic              tx_filled_i,
   input logic              busy_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_rd_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              irq_o,
   input logic [N-1:0]      flag_q,
   input logic [N-1:0]      mask_q,
   input logic [CODE_W-1:0] vec_code
);
   logic [N-1:0] pend, rep_oh;
   logic         vec_rd, stat_rd;

   assign pend    = flag_q & mask_q;
   assign rep_oh  = (vec_code == '0) ? '0 : (N'(1) << (vec_code - CODE_W'(1)));
   assign vec_rd  = bus_rd_i && bus_addr_i == ADDR_W'(REG_VEC);
   assign stat_rd = bus_rd_i && bus_addr_i == ADDR_W'(REG_STAT);

   p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   p_no_spont_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q == '0 && evt_i == '0) |=> (flag_q == '0));

   p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_code <= CODE_W'(N));

   p_zero_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend == '0) |-> (vec_code == '0));

   p_lowest_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_code != '0) |-> ((pend & rep_oh) != '0 && (pend & (rep_oh - N'(1))) == '0));

   p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_rd && vec_code != '0 && (rep_oh & DATA_HELD) == '0 && (rep_oh & evt_i) == '0)
      |=> ((flag_q & $past(rep_oh)) == '0));

   p_rx_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_rd && vec_code == CODE_W'(EV_RX_RDY + 1) && !rx_drained_i) |=> flag_q[EV_RX_RDY]);

   p_tx_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_rd && vec_code == CODE_W'(EV_TX_RDY + 1) && !tx_filled_i) |=> flag_q[EV_TX_RDY]);

   p_irq_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (vec_code != '0));

   p_busy_lvl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_rd |-> (bus_rdata_o[BUSY_BIT] == busy_i));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .N(N), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .evt_i        (evt_i),
   .rx_drained_i (rx_drained_i),
   .tx_filled_i  (tx_filled_i),
   .busy_i       (busy_i),
   .bus_addr_i   (bus_addr_i),
   .bus_rd_i     (bus_rd_i),
   .bus_rdata_o  (bus_rdata_o),
   .irq_o        (irq_o),
   .flag_q       (flag_q),
   .mask_q       (mask_q),
   .vec_code     (vec_code)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evt = '0;
   logic        drx = 1'b0, dtx = 1'b0, rsfull = 1'b0, busy = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .rx_drained_i(drx), .tx_filled_i(dtx),
      .rsfull_i(rsfull), .busy_i(busy), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one bus cycle; read data and irq sampled before the edge
   task automatic cyc(input logic [1:0] a, input logic w, input logic r, input logic [15:0] d,
                      input logic [6:0] e, input logic rx, input logic tx,
                      output logic [15:0] rv, output logic iv);
      @(negedge clk);
      addr = a; wr = w; rd = r; wdata = d; evt = e; drx = rx; dtx = tx;
      #1;
      rv = rdata; iv = irq;
      @(posedge clk);
      #1;
      wr = 1'b0; rd = 1'b0; evt = '0; drx = 1'b0; dtx = 1'b0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      logic [15:0] rv; logic iv;
      cyc(a, 1'b1, 1'b0, d, '0, 1'b0, 1'b0, rv, iv);
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [15:0] rv, output logic iv);
      cyc(a, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0, rv, iv);
   endtask

   task automatic side(input logic [6:0] e, input logic rx, input logic tx);
      logic [15:0] rv; logic iv;
      cyc(2'd3, 1'b0, 1'b0, '0, e, rx, tx, rv, iv);
   endtask

   function automatic int low_code(input logic [6:0] v);
      for (int j = 0; j < 7; j++) if (v[j]) return j + 1;
      return 0;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      logic        iv;
      logic [6:0]  masks [4];
      masks[0] = 7'h7f; masks[1] = 7'h55; masks[2] = 7'h2a; masks[3] = 7'h00;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_reg(2'd0, rv, iv); chk("R1 mask", rv, 0); chk("R1 irq", iv, 0);
      rd_reg(2'd1, rv, iv); chk("R1 status", rv, 0);
      rd_reg(2'd2, rv, iv); chk("R1 vector", rv, 0);

      // R12 mask width, unmapped address
      wr_reg(2'd0, 16'hffff);
      rd_reg(2'd0, rv, iv); chk("R12 mask readback", rv, 16'h007f);
      rd_reg(2'd3, rv, iv); chk("R12 unmapped", rv, 0);

      // R3 single-event codes
      for (int j = 0; j < 7; j++) begin
         side(7'(1 << j), 1'b0, 1'b0);
         rd_reg(2'd2, rv, iv); chk("R3 code", rv, j + 1);
         wr_reg(2'd1, 16'h007f);
      end

      // R9 event beats write-one clear
      side(7'h02, 1'b0, 1'b0);
      cyc(2'd1, 1'b1, 1'b0, 16'h0002, 7'h02, 1'b0, 1'b0, rv, iv);
      rd_reg(2'd1, rv, iv); chk("R9 w1c vs event", rv, 16'h0002);
      // R9 event beats vector acknowledge
      cyc(2'd2, 1'b0, 1'b1, '0, 7'h02, 1'b0, 1'b0, rv, iv); chk("R9 vec code", rv, 2);
      rd_reg(2'd2, rv, iv); chk("R9 vec ack vs event", rv, 2);
      rd_reg(2'd2, rv, iv); chk("R6 after ack", rv, 0);
      // R9 event beats data-path clear
      side(7'h08, 1'b0, 1'b0);
      side(7'h08, 1'b1, 1'b0);
      rd_reg(2'd1, rv, iv); chk("R9 drain vs event", rv, 16'h0008);

      // R7 data-ready flags held across vector reads
      rd_reg(2'd2, rv, iv); chk("R7 rx first", rv, 4);
      rd_reg(2'd2, rv, iv); chk("R7 rx held", rv, 4);
      side('0, 1'b1, 1'b0);
      rd_reg(2'd2, rv, iv); chk("R7 rx drained", rv, 0);
      side(7'h10, 1'b0, 1'b0);
      rd_reg(2'd2, rv, iv); chk("R7 tx first", rv, 5);
      rd_reg(2'd2, rv, iv); chk("R7 tx held", rv, 5);
      side('0, 1'b0, 1'b1);
      rd_reg(2'd2, rv, iv); chk("R7 tx filled", rv, 0); chk("R10 idle irq", iv, 0);

      // R11 level bits, write ignored
      rsfull = 1'b1; busy = 1'b1;
      wr_reg(2'd1, 16'h1800);
      rd_reg(2'd1, rv, iv); chk("R11 levels", rv, 16'h1800);
      rsfull = 1'b0;
      rd_reg(2'd1, rv, iv); chk("R11 rsfull low", rv, 16'h1000);

      // sweep: every event combination against several masks
      for (int mi = 0; mi < 4; mi++) begin
         for (int p = 0; p < 128; p++) begin
            logic [6:0]  m, pv, q, f;
            logic [15:0] lv;
            int          e;
            m  = masks[mi];
            pv = 7'(p);
            rsfull = pv[0] ^ pv[3];
            busy   = pv[6];
            lv = {3'b000, busy, rsfull, 11'h000};
            wr_reg(2'd1, 16'h007f);
            wr_reg(2'd0, {9'h000, m});
            side(pv, 1'b0, 1'b0);
            rd_reg(2'd1, rv, iv);
            chk("R2 status capture", rv, {9'h000, pv} | lv);
            chk("R10 irq", iv, (pv & m) != 0);
            q = 7'((p * 5 + 3) & 7'h7f);
            wr_reg(2'd1, {9'h000, q} | 16'h1800);
            f = pv & ~q;
            rd_reg(2'd1, rv, iv);
            chk("R8 write-one clear", rv, {9'h000, f} | lv);
            for (int s = 0; s < 9; s++) begin
               e = low_code(f & m);
               rd_reg(2'd2, rv, iv);
               if (s == 0) chk("R5 priority", rv, e);
               else        chk("R6 service order", rv, e);
               if (m == 0) chk("R4 masked", rv, 0);
               chk("R10 irq vs vector", iv, e != 0);
               if (e == 0) break;
               if (e == 4)      side('0, 1'b1, 1'b0);
               else if (e == 5) side('0, 1'b0, 1'b1);
               f[e-1] = 1'b0;
            end
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule